// File: doc/BRIEF.md
# Serial Line Transmitter with Ready/Valid Word Input

This block takes data words from user logic through a ready/valid stream handshake and sends each one as an asynchronous serial frame on one output line. A frame is a low start bit, the data bits least significant first, and one high stop bit. The line rests high between frames.

The bit period is eight times the `prescale_i` input, counted in clock cycles. The value is chosen as clock frequency divided by eight times the baud rate. The input is not copied inside the block. The counter reloads from it at every bit boundary, so software should change it only while the block is idle. Only one word is held at a time. `tready_o` stays low for the whole frame, so the producer stalls until the frame ends. `busy_o` shows that a frame is in progress.

Top module: `ser_tx`

## Requirements
- R1: While reset is asserted and afterwards until a word is accepted, `txd_o` is 1, `busy_o` is 0 and `tready_o` is 1.
- R2: A word is taken only on a rising clock edge where both `tvalid_i` and `tready_o` are 1. `tready_o` is 0 from the cycle after that edge until the frame ends, and it is always the inverse of `busy_o`.
- R3: The frame order on `txd_o` is one start bit at 0, then bit 0 through bit DATA_WIDTH-1 of the accepted word, then one stop bit at 1.
- R4: Each bit of the frame, start and stop included, lasts exactly 8*`prescale_i` clock cycles (for `prescale_i` >= 1). The start bit appears in the cycle right after the accepting edge.
- R5: `busy_o` is 1 for exactly (DATA_WIDTH+2)*8*`prescale_i` cycles, starting in the cycle after acceptance.
- R6: `tready_o` returns to 1 in the cycle where the stop bit ends. A word offered at that moment is accepted on the next edge, so the following start bit comes after exactly one extra cycle of high line.
- R7: While no word is offered, `txd_o` stays at 1 and `busy_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | PRESCALE_W | Bit period divided by 8, in clock cycles |
| tdata_i | input | DATA_WIDTH | Word to send |
| tvalid_i | input | 1 | Word offered |
| tready_o | output | 1 | Block can take a word |
| txd_o | output | 1 | Serial output, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong bit index or shift register shows up as a wrong level on `txd_o` in the very bit period where the fault occurs. The bench compares the line against its arithmetic model in every cycle of every frame, for all 256 byte values. A fault in the divider count moves a bit edge by at least one cycle, and checking the first and last cycle of each bit catches it at once. A wrong busy or ready state shows as an early or late `tready_o`. This is seen at the frame boundary, or as a lost back-to-back word.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  // bit period is 8 * prescale clock cycles
  localparam int unsigned OVERSAMPLE_LOG2 = 3;
endpackage

// File: rtl/ser_tx_bit_timer.sv
module ser_tx_bit_timer
  import ser_tx_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 16,
  localparam int unsigned CNT_W = PRESCALE_W + OVERSAMPLE_LOG2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PRESCALE_W-1:0] prescale_i,
  input  logic                  load_i,
  input  logic                  run_i,
  output logic                  tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_m1;

  assign period_m1 = {prescale_i, {OVERSAMPLE_LOG2{1'b0}}} - CNT_W'(1);
  assign tick_o    = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i || tick_o)     cnt_q <= period_m1;
    else if (run_i)                cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int unsigned DATA_WIDTH = 8,
  localparam int unsigned SH_W  = DATA_WIDTH + 1,
  localparam int unsigned IDX_W = $clog2(SH_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [DATA_WIDTH-1:0] data_i,
  input  logic                  tick_i,
  output logic                  txd_o,
  output logic                  busy_o
);
  logic [SH_W-1:0]  sh_q;
  logic [IDX_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= {1'b1, data_i};   // stop bit sits above data
      left_q <= IDX_W'(SH_W);
      txd_o  <= 1'b0;             // start bit
      busy_o <= 1'b1;
    end else if (tick_i) begin
      if (left_q == '0) begin
        busy_o <= 1'b0;           // stop bit done, line already high
      end else begin
        txd_o  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
        left_q <= left_q - IDX_W'(1);
      end
    end
  end

  // R7
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  // R3
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  // R3
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(txd_o));
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned DATA_WIDTH = 8,
  parameter int unsigned PRESCALE_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PRESCALE_W-1:0] prescale_i,
  input  logic [DATA_WIDTH-1:0] tdata_i,
  input  logic                  tvalid_i,
  output logic                  tready_o,
  output logic                  txd_o,
  output logic                  busy_o
);
  logic accept, tick;

  assign tready_o = !busy_o;
  assign accept   = tvalid_i && tready_o;

  ser_tx_bit_timer #(.PRESCALE_W(PRESCALE_W)) timer_i (
    .clk_i, .rst_ni, .prescale_i,
    .load_i (accept),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  ser_tx_shifter #(.DATA_WIDTH(DATA_WIDTH)) shifter_i (
    .clk_i, .rst_ni,
    .load_i (accept),
    .data_i (tdata_i),
    .tick_i (tick),
    .txd_o,
    .busy_o
  );

  // R2
  accept_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_i && tready_o) |=> (busy_o && !tready_o));
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(tick)) |-> $stable(txd_o));
endmodule

// File: tb/ser_tx_tb_top.sv
`timescale 1ns/1ps
module ser_tx_tb_top;
  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] prescale = 16'd1;
  logic [DW-1:0] tdata = '0;
  logic          tvalid = 1'b0;
  logic          tready, txd, busy;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  ser_tx #(.DATA_WIDTH(DW), .PRESCALE_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale),
    .tdata_i(tdata), .tvalid_i(tvalid),
    .tready_o(tready), .txd_o(txd), .busy_o(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the negedge where the stop bit has ended.
  task automatic send(input logic [DW-1:0] d, input int p);
    int len, m;
    prescale = PW'(p);
    while (!tready) @(negedge clk);
    tdata  = d;
    tvalid = 1'b1;
    @(negedge clk);
    tvalid = 1'b0;
    len = (DW + 2) * 8 * p;
    for (m = 0; m <= len; m++) begin
      int idx;
      logic exp_txd;
      idx = m / (8 * p);
      if (idx == 0)       exp_txd = 1'b0;
      else if (idx <= DW) exp_txd = d[idx-1];
      else                exp_txd = 1'b1;
      chk("R3/R4 txd", txd, exp_txd);
      chk("R5 busy", busy, m < len);
      chk("R2/R6 tready", tready, m >= len);
      if (m < len) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 tready in reset", tready, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 txd after reset", txd, 1'b1);
    chk("R1 tready after reset", tready, 1'b1);
    // R3 R4 R5 R6: every byte, back to back, prescale 1
    for (int v = 0; v < 256; v++) send(8'(v), 1);
    // R7: idle gap with no word offered
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 idle txd", txd, 1'b1);
      chk("R7 idle busy", busy, 1'b0);
    end
    // R4: other bit periods
    for (int p = 2; p <= 5; p++) begin
      send(8'hA5, p);
      send(8'h3C, p);
      send(8'h01, p);
      send(8'h80, p);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule